// File: doc/BRIEF.md
# Multi-Channel Register Command Decoder

This block is the control-port engine of a four-channel device. A host frames each transaction with an active-low chip select and shifts bits in most-significant first, one bit per `bit_stb` pulse. The first full byte of a frame is a command. It names a direction, a target space and an address. The target space is one of three: the per-channel local registers, the shared global registers, or an external coefficient memory reached through a separate word port. The bytes that follow carry write data, or they clock out a read response.

A channel-enable field sits in one global register. A local write lands in every enabled channel at once, so one frame can program a single channel, a subset, or all four. The two lowest address bits set a burst length of one to four registers, and the burst walks downward from the given address. A read response always opens with a fixed identification byte. Illegal commands raise a one-cycle error pulse and leave all state untouched.

Top module: `cmdec_top`

## Requirements
- R1: Bits are sampled on `bit_stb` while `cs_n` is low, eight per byte, most significant first. The first byte of a frame is the command: bit 7 = 1 means write and 0 means read; bits 6:5 give the type (00 local, 01 global, 11 coefficient memory, 10 illegal); bits 4:0 give the address or the memory block.
- R2: A local or global access with address low bits n covers n+1 registers, at addresses addr, addr-1, down to the base with the low two bits cleared. Register index is address bits 2:0. Data bytes beyond the burst are ignored.
- R3: The channel-enable field is bits 3:0 of global register 5, where bit i enables channel i. A local write updates that register in every enabled channel, and in no other channel.
- R4: Global accesses use the shared bank whatever the channel-enable field holds.
- R5: In a read, the byte clocked out during the first data byte is 0x81. The register values follow in burst order, then 0x00. `miso` shows the MSB of the outgoing byte and shifts after each strobe.
- R6: A local read returns the registers of the single enabled channel.
- R7: Two cases are illegal: command type 10, and a local read with a number of enabled channels other than one. In either case `err` is high for exactly one cycle after the command's last bit. No register or memory is written, and every response byte is 0x00.
- R8: Raising `cs_n` discards a partial byte and the rest of the burst. Registers written by completed bytes keep their values, and the next frame starts again with a command byte.
- R9: A memory write to block b takes 16 data bytes forming words 7 down to 0. Each word is a high byte (bits 5:0 used) followed by a low byte. In the strobe cycle of the low byte's last bit, `cram_we` is high with `cram_addr` = {b, word} and the 14-bit word on `cram_wdata`.
- R10: A memory read to block b returns 0x81, then for words 7 down to 0 the byte {00, word[13:8]} followed by word[7:0]. These are fetched from `cram_rdata` at `cram_addr` = {b, word}.
- R11: After reset all registers and the enable field are 0, and `miso` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| bit_stb | input | 1 | One-cycle strobe marking a bit transfer |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial response out |
| err | output | 1 | One-cycle illegal-command pulse |
| cram_we | output | 1 | Coefficient word write enable |
| cram_addr | output | 8 | Coefficient word address {block, word} |
| cram_wdata | output | 14 | Coefficient word write data |
| cram_rdata | input | 14 | Coefficient word read data for `cram_addr` |

## Verification
Several properties are checked every cycle by the assertions:
- A local write enable never reaches a disabled channel.
- Nothing is written after an illegal command.
- The burst counter stays within its bound.
- The error pulse follows a completed command byte.
- A read response loads the identification byte.
- The bit counter clears while chip select is high.

Other behaviours can only be shown by the bench's scenarios:
- The downward burst order.
- Broadcast contents per channel.
- Survival of earlier bytes after an aborted burst.
- The exact byte stream of register and memory reads.

// File: rtl/cmdec_pkg.sv
`timescale 1ns/1ps
package cmdec_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ID_BYTE = 8'h81;
    typedef enum logic [1:0] {
        CT_LOC = 2'b00,
        CT_GLB = 2'b01,
        CT_ILL = 2'b10,
        CT_RAM = 2'b11
    } cmd_type_e;
endpackage

// File: rtl/cmdec_rx.sv
`timescale 1ns/1ps
module cmdec_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       bit_stb,
    input  logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        logic [2:0] cnt;
        logic [6:0] sh;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d = q;
        if (cs_n) begin
            d.cnt = '0;
        end else if (bit_stb) begin
            d.sh  = {q.sh[5:0], mosi};
            d.cnt = q.cnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done = !cs_n && bit_stb && (q.cnt == 3'd7);
    assign rx_byte   = {q.sh, mosi};

    AST_CS_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (q.cnt == 3'd0)); // R8
endmodule

// File: rtl/cmdec_regs.sv
`timescale 1ns/1ps
module cmdec_regs #(
    parameter int NCH      = 4,
    parameter int NREG     = 8,
    parameter int CHEN_IDX = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          lwe,
    input  logic                    gwe,
    input  logic [$clog2(NREG)-1:0] addr,
    input  logic [7:0]              wdata,
    input  logic [$clog2(NCH)-1:0]  rch,
    output logic [7:0]              lrdata,
    output logic [7:0]              grdata,
    output logic [NCH-1:0]          chen
);
    localparam int IW = $clog2(NREG);

    logic [7:0] glb_q [NREG];
    logic [7:0] glb_d [NREG];
    logic [7:0] loc_q [NCH][NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) glb_d[i] = glb_q[i];
        if (gwe) glb_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) glb_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) glb_q[i] <= glb_d[i];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [7:0] bank_d [NREG];
        always_comb begin
            for (int i = 0; i < NREG; i++) bank_d[i] = loc_q[c][i];
            if (lwe[c]) bank_d[addr] = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NREG; i++) loc_q[c][i] <= '0;
            end else begin
                for (int i = 0; i < NREG; i++) loc_q[c][i] <= bank_d[i];
            end
        end
    end

    assign lrdata = loc_q[rch][addr];
    assign grdata = glb_q[addr];
    assign chen   = glb_q[IW'(CHEN_IDX)][NCH-1:0];
endmodule

// File: rtl/cmdec_top.sv
`timescale 1ns/1ps
module cmdec_top
    import cmdec_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int NREG     = 8,
    parameter int CHEN_IDX = 5,
    parameter int BLK_W    = 5,
    parameter int WPB      = 8,
    parameter int CW       = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          bit_stb,
    input  logic                          mosi,
    output logic                          miso,
    output logic                          err,
    output logic                          cram_we,
    output logic [BLK_W+$clog2(WPB)-1:0]  cram_addr,
    output logic [CW-1:0]                 cram_wdata,
    input  logic [CW-1:0]                 cram_rdata
);
    localparam int IW    = $clog2(NREG);
    localparam int CHW   = $clog2(NCH);
    localparam int WIW   = $clog2(WPB);
    localparam int RBYT  = 2 * WPB;
    localparam int REMW  = $clog2(RBYT + 1);
    localparam int HIW   = CW - BYTE_W;

    typedef struct packed {
        logic             phase;  // 0: command byte, 1: data bytes
        logic             wr;
        cmd_type_e        typ;
        logic             bad;
        logic [IW-1:0]    ptr;
        logic [REMW-1:0]  rem;
        logic [BLK_W-1:0] blk;
        logic [HIW-1:0]   hold;
        logic [7:0]       tx;
        logic             err;
    } st_t;

    st_t q, d;

    logic           byte_done;
    logic [7:0]     rxb;
    logic [NCH-1:0] chen;
    logic [NCH-1:0] lwe;
    logic           gwe;
    logic [7:0]     lrd, grd;
    logic [CHW-1:0] rch;
    logic           cmd_done;
    logic           cmd_bad;
    cmd_type_e      cmd_typ;

    cmdec_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .mosi(mosi),
        .byte_done(byte_done), .rx_byte(rxb)
    );

    cmdec_regs #(.NCH(NCH), .NREG(NREG), .CHEN_IDX(CHEN_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .lwe(lwe), .gwe(gwe), .addr(q.ptr),
        .wdata(rxb), .rch(rch), .lrdata(lrd), .grdata(grd), .chen(chen)
    );

    always_comb begin
        rch = '0;
        for (int c = NCH - 1; c >= 0; c--) if (chen[c]) rch = CHW'(c);
    end

    assign cmd_done = byte_done && !q.phase;
    assign cmd_typ  = cmd_type_e'(rxb[6:5]);
    assign cmd_bad  = (cmd_typ == CT_ILL) ||
                      (!rxb[7] && cmd_typ == CT_LOC && $countones(chen) != 1);

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        lwe     = '0;
        gwe     = 1'b0;
        cram_we = 1'b0;
        if (cs_n) begin
            d.phase = 1'b0;
            d.tx    = '0;
            d.rem   = '0;
        end else if (cmd_done) begin
            d.phase = 1'b1;
            d.wr    = rxb[7];
            d.typ   = cmd_typ;
            d.ptr   = rxb[IW-1:0];
            d.blk   = rxb[BLK_W-1:0];
            d.bad   = cmd_bad;
            d.err   = cmd_bad;
            d.rem   = (cmd_typ == CT_RAM) ? REMW'(RBYT) : REMW'(rxb[1:0]) + REMW'(1);
            d.tx    = (!rxb[7] && !cmd_bad) ? ID_BYTE : 8'h00;
        end else if (byte_done) begin
            d.tx = 8'h00;
            if (!q.bad && q.rem != '0) begin
                d.rem = q.rem - REMW'(1);
                if (q.typ == CT_RAM) begin
                    if (q.wr) begin
                        if (!q.rem[0]) d.hold = rxb[HIW-1:0];
                        else           cram_we = 1'b1;
                    end else begin
                        d.tx = !q.rem[0] ? 8'(cram_rdata[CW-1:BYTE_W]) : cram_rdata[7:0];
                    end
                end else begin
                    d.ptr = q.ptr - IW'(1);
                    if (q.wr) begin
                        if (q.typ == CT_LOC) lwe = chen;
                        else                 gwe = 1'b1;
                    end else begin
                        d.tx = (q.typ == CT_LOC) ? lrd : grd;
                    end
                end
            end
        end else if (bit_stb) begin
            d.tx = {q.tx[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso       = q.tx[7];
    assign err        = q.err;
    assign cram_addr  = {q.blk, WIW'((q.rem - REMW'(1)) >> 1)};
    assign cram_wdata = {q.hold, rxb};

    AST_ERR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cmd_done)); // R7
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase && q.bad) |-> (lwe == '0 && !gwe && !cram_we)); // R7
    AST_LWE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (lwe & ~chen) == '0); // R3
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.rem <= REMW'(RBYT)); // R2
    AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !rxb[7] && !cmd_bad) |=> (miso == ID_BYTE[7])); // R5
    AST_RD_ONE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase && !q.wr && q.typ == CT_LOC && !q.bad) |-> ($countones(chen) == 1)); // R6
    AST_CRAM_WE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> (q.typ == CT_RAM && q.wr && q.phase)); // R9
endmodule

// File: tb/sim_cmdec_top.sv
`timescale 1ns/1ps
module sim_cmdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        bit_stb = 1'b0;
    logic        mosi = 1'b0;
    logic        miso, err, cram_we;
    logic [7:0]  cram_addr;
    logic [13:0] cram_wdata, cram_rdata;

    always #5 clk = ~clk;

    cmdec_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .mosi(mosi),
        .miso(miso), .err(err), .cram_we(cram_we), .cram_addr(cram_addr),
        .cram_wdata(cram_wdata), .cram_rdata(cram_rdata)
    );

    logic [13:0] cmem [256];
    initial for (int i = 0; i < 256; i++) cmem[i] = '0;
    always @(posedge clk) if (cram_we) cmem[cram_addr] <= cram_wdata;
    assign cram_rdata = cmem[cram_addr];

    int n_run = 0, n_fail = 0, err_seen = 0, e0;
    bit done = 1'b0;
    always @(posedge clk) if (rst_n && err) err_seen++;

    logic [7:0] txb [0:17];
    logic [7:0] rxb [0:17];

    // {cmd, data bytes, data (5 bytes), expected response (5 bytes), check, expect err}
    localparam int NV = 16;
    localparam logic [93:0] VEC [NV] = '{
        {8'h25, 4'd3, 40'h0,          40'h8100000000, 1'b1, 1'b0},
        {8'hA5, 4'd2, 40'h0F33000000, 40'h0,          1'b0, 1'b0},
        {8'h83, 4'd4, 40'h1122334400, 40'h0,          1'b0, 1'b0},
        {8'h03, 4'd5, 40'h0,          40'h0,          1'b1, 1'b1},
        {8'hA5, 4'd2, 40'h0433000000, 40'h0,          1'b0, 1'b0},
        {8'h86, 4'd3, 40'hAABBCC0000, 40'h0,          1'b0, 1'b0},
        {8'h07, 4'd5, 40'h0,          40'h8100AABBCC, 1'b1, 1'b0},
        {8'hA5, 4'd2, 40'h0133000000, 40'h0,          1'b0, 1'b0},
        {8'h07, 4'd5, 40'h0,          40'h8100000000, 1'b1, 1'b0},
        {8'h03, 4'd5, 40'h0,          40'h8111223344, 1'b1, 1'b0},
        {8'h25, 4'd4, 40'h0,          40'h8101330000, 1'b1, 1'b0},
        {8'hC0, 4'd1, 40'hFF00000000, 40'h0,          1'b0, 1'b1},
        {8'h40, 4'd2, 40'h0,          40'h0,          1'b1, 1'b1},
        {8'hA5, 4'd2, 40'h0033000000, 40'h0,          1'b0, 1'b0},
        {8'hA1, 4'd2, 40'h5A6B000000, 40'h0,          1'b0, 1'b0},
        {8'h21, 4'd3, 40'h0,          40'h815A6B0000, 1'b1, 1'b0}
    };

    function automatic string vreq(int v);
        case (v)
            0:       return "R11";
            3, 12:   return "R7";
            6:       return "R6";
            8, 9:    return "R3";
            10:      return "R5";
            15:      return "R4";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [13:0] wval(int k);
        return 14'(14'h02A5 + k * 14'h03C7);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %04h expected %04h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] v, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            mosi = v[7-i];
            r[7-i] = miso;
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] cmd, input int nb, input int pbits);
        logic [7:0] junk;
        @(negedge clk);
        cs_n = 1'b0;
        xfer(cmd, 8, junk);
        for (int b = 0; b < nb; b++) xfer(txb[b], 8, rxb[b]);
        if (pbits > 0) xfer(txb[nb], pbits, junk);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [93:0] ent;
        logic [39:0] dat, exp;
        int nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {15'd0, miso}, 16'd0);
        check("R11", {15'd0, err}, 16'd0);

        // R1..R7, R11 through the vector table
        for (int v = 0; v < NV; v++) begin
            ent = VEC[v];
            nb  = int'(ent[85:82]);
            dat = ent[81:42];
            exp = ent[41:2];
            for (int b = 0; b < 5; b++) txb[b] = dat[39-8*b -: 8];
            e0 = err_seen;
            frame(ent[93:86], nb, 0);
            if (ent[1])
                for (int b = 0; b < nb; b++)
                    check(vreq(v), {8'h0, rxb[b]}, {8'h0, exp[39-8*b -: 8]});
            check("R7", 16'(err_seen - e0), {15'd0, ent[0]});
        end

        // R8: abort after one byte of a two-byte global burst
        txb[0] = 8'h02; txb[1] = 8'h99;
        frame(8'hA5, 1, 0);
        // R8: abort a local burst mid-byte (channel 1 enabled)
        txb[0] = 8'h77; txb[1] = 8'h66; txb[2] = 8'h55;
        frame(8'h83, 2, 3);
        frame(8'h03, 5, 0);
        check("R8", {8'h0, rxb[0]}, 16'h0081);
        check("R8", {8'h0, rxb[1]}, 16'h0077);
        check("R8", {8'h0, rxb[2]}, 16'h0066);
        check("R8", {8'h0, rxb[3]}, 16'h0033);
        check("R8", {8'h0, rxb[4]}, 16'h0044);
        frame(8'h25, 3, 0);
        check("R8", {8'h0, rxb[1]}, 16'h0002);
        check("R8", {8'h0, rxb[2]}, 16'h0033);

        // R9: coefficient block 2 write, high bits of high bytes set to ones
        for (int j = 0; j < 8; j++) begin
            txb[2*j]   = {2'b11, wval(7-j)[13:8]};
            txb[2*j+1] = wval(7-j)[7:0];
        end
        frame(8'hE2, 16, 0);
        for (int k = 0; k < 8; k++)
            check("R9", {2'b0, cmem[{5'd2, 3'(k)}]}, {2'b0, wval(k)});
        check("R9", {2'b0, cmem[{5'd3, 3'd7}]}, 16'd0);

        // R10: read block 2 back
        frame(8'h62, 17, 0);
        check("R10", {8'h0, rxb[0]}, 16'h0081);
        for (int j = 0; j < 8; j++) begin
            check("R10", {8'h0, rxb[1+2*j]}, {10'h0, wval(7-j)[13:8]});
            check("R10", {8'h0, rxb[2+2*j]}, {8'h0, wval(7-j)[7:0]});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule